// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a field-configurable logic device. A connection map decides which array input lines each product term uses. The input lines are the true and inverted forms of twelve dedicated inputs and ten feedback signals. The fixed OR plane then forms ten sums, and the sums do not all use the same number of terms. Each output also has its own enable term. Two more terms are shared by all outputs: one is used by the surrounding logic as a synchronous preset and the other as an asynchronous clear. Pin drivers, the output registers and electrical timing sit outside this block.

The connection map is loaded one product-term row per cycle through a configuration port. Each row is a 44-bit word in which a 1 marks a closed connection. A start strobe erases the whole array and moves the controller into its loading state. While loading is in progress every array output is held at 0. The controller leaves loading after the last row has been written.

The controller has two states. `ST_RUN` evaluates the array. `ST_LOAD` accepts rows. The transitions are:
- START: `ST_RUN` to `ST_LOAD` on `cfg_start`.
- RESTART: `ST_LOAD` to `ST_LOAD` on `cfg_start`, which erases the array again and sets the row counter back to 0.
- LAST_ROW: `ST_LOAD` to `ST_RUN` when the write of row 131 is accepted.

Top module: `sop_array`

## Requirements
- R1: Signal s is `ded_in[s]` for s from 0 to 11 and `fb_in[s-12]` for s from 12 to 21. Array line 2s carries signal s, and line 2s+1 carries its inverse.
- R2: Bit k of a row set to 1 means line k is connected to that product term. A term is 1 exactly when every connected line is 1, so a row with no bit set (erased) gives 1.
- R3: A term with both line 2s and line 2s+1 connected gives 0, whatever the inputs are.
- R4: The rows are laid out by output. For output n, the first row is its enable term and the next size(n) rows are its sum terms. The sizes for outputs 0 to 9 are 8,10,12,14,16,16,14,12,10,8. Row 130 is the preset term and row 131 is the clear term, for 132 rows in total.
- R5: In `ST_RUN`, `sum_o[n]` is the OR of output n's sum terms and `oe_o[n]` is its enable term. `preset_o` and `clear_o` are rows 130 and 131. All of these are combinational from the inputs.
- R6: Reset erases every row and enters `ST_RUN`, so every output reads 1 after reset.
- R7: `cfg_start` erases every row at the next clock edge and enters `ST_LOAD` at row 0. Each later cycle with `cfg_wr` high writes `cfg_row` to the current row and advances the row counter by one.
- R8: In `ST_LOAD`, `sum_o`, `oe_o`, `preset_o` and `clear_o` are all 0.
- R9: The clock edge that accepts the write of row 131 returns the controller to `ST_RUN`. From the following cycle the outputs follow the new map.
- R10: `cfg_start` in `ST_LOAD` erases the array again and restarts loading at row 0.
- R11: `cfg_wr` in `ST_RUN` leaves the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Erase the array and begin loading rows |
| cfg_wr | input | 1 | Write `cfg_row` to the current row while loading |
| cfg_row | input | 44 | Connection row; 1 = connected |
| ded_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Feedback signals from the I/O cells |
| sum_o | output | 10 | OR sum for each output |
| oe_o | output | 10 | Enable term for each output |
| preset_o | output | 1 | Global preset term |
| clear_o | output | 1 | Global clear term |

## Verification
The assertions assume three things about the inputs. `cfg_wr` is only meaningful while loading. `cfg_start` and `cfg_wr` are stable across each clock edge. The input vectors are settled before they are sampled. The stimulus drives every input on the falling edge and checks outputs shortly afterwards. It raises `cfg_start` and `cfg_wr` only in the cycles of a load sequence, with a single deliberate stray write in `ST_RUN`. Random maps use rows with zero to three connections, so that terms come out true, false and conflicting in comparable numbers.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } cfg_state_e;

    // Terms in the sum of output n: smallest at the ends, largest in the middle.
    function automatic int sum_size(input int n, input int n_out,
                                    input int min_terms, input int step);
        int d;
        d = (n < (n_out - 1 - n)) ? n : (n_out - 1 - n);
        return min_terms + step * d;
    endfunction

    // First row (the enable term) of output n.
    function automatic int out_base(input int n, input int n_out,
                                    input int min_terms, input int step);
        int b;
        b = 0;
        for (int k = 0; k < n; k++) begin
            b += 1 + sum_size(k, n_out, min_terms, step);
        end
        return b;
    endfunction

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl #(
    parameter int N_ROWS = 132,
    localparam int AW = $clog2(N_ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    output logic          erase_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic          loading_o
);
    import sop_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(N_ROWS - 1);

    cfg_state_e    state_q, state_d;
    logic [AW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (start_i) begin
                    state_d = ST_LOAD;
                    cnt_d   = '0;
                end
            end
            ST_LOAD: begin
                if (start_i) begin
                    cnt_d = '0;
                end else if (wr_i) begin
                    if (cnt_q == LAST) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        erase_o   = 1'b0;
        we_o      = 1'b0;
        loading_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                erase_o = start_i;
            end
            ST_LOAD: begin
                loading_o = 1'b1;
                erase_o   = start_i;
                we_o      = wr_i && !start_i;
            end
            default: begin
                loading_o = 1'b0;
            end
        endcase
    end

    assign addr_o = cnt_q;

    // R7, R10: a start always lands in loading at row 0
    a_r7_start_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (loading_o && addr_o == '0));

    // R9: accepting the last row ends loading
    a_r9_last_row_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (loading_o && wr_i && !start_i && addr_o == LAST) |=> !loading_o);

    // R7: the row counter stays within the array
    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        loading_o |-> (addr_o <= LAST));

endmodule

// File: rtl/sop_conn_store.sv
module sop_conn_store #(
    parameter int N_ROWS = 132,
    parameter int LINES  = 44,
    localparam int AW = $clog2(N_ROWS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase_i,
    input  logic                          we_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [LINES-1:0]              data_i,
    output logic [N_ROWS-1:0][LINES-1:0]  rows_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_o <= '0;
        end else if (erase_i) begin
            rows_o <= '0;
        end else if (we_i) begin
            rows_o[addr_i] <= data_i;
        end
    end

    // R7: erase opens every connection
    a_r7_erase_opens_all: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (rows_o == '0));

    // R7: a write lands in the addressed row
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !erase_i) |=> (rows_o[$past(addr_i)] == $past(data_i)));

endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
    parameter int LINES = 44,
    localparam int N_SIG = LINES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] conn_i,
    input  logic [LINES-1:0] line_i,
    output logic             term_o
);

    logic [N_SIG-1:0] both_pol;

    // an open connection (0) passes 1 into the AND
    assign term_o = &(line_i | ~conn_i);

    for (genvar s = 0; s < N_SIG; s++) begin : g_pair
        assign both_pol[s] = conn_i[2*s] & conn_i[2*s+1];
    end

    // R3: a term tied to both polarities of one signal is dead
    a_r3_conflict_false: assert property (@(posedge clk) disable iff (!rst_n)
        (|both_pol) |-> !term_o);

    // R2: an erased term is always true
    a_r2_erased_true: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_i == '0) |-> term_o);

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_DED     = 12,
    parameter int N_OUT     = 10,
    parameter int MIN_TERMS = 8,
    parameter int TERM_STEP = 2,
    localparam int N_SIG      = N_DED + N_OUT,
    localparam int LINES      = 2 * N_SIG,
    localparam int ROW_PRESET = sop_pkg::out_base(N_OUT, N_OUT, MIN_TERMS, TERM_STEP),
    localparam int ROW_CLEAR  = ROW_PRESET + 1,
    localparam int N_ROWS     = ROW_PRESET + 2,
    localparam int AW         = $clog2(N_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             cfg_wr,
    input  logic [LINES-1:0] cfg_row,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_OUT-1:0] fb_in,
    output logic [N_OUT-1:0] sum_o,
    output logic [N_OUT-1:0] oe_o,
    output logic             preset_o,
    output logic             clear_o
);

    logic                         erase, we, loading;
    logic [AW-1:0]                addr;
    logic [N_ROWS-1:0][LINES-1:0] rows;
    logic [N_SIG-1:0]             sig;
    logic [LINES-1:0]             lines;
    logic [N_ROWS-1:0]            term;
    logic [N_OUT-1:0]             sum_raw, oe_raw;

    sop_cfg_ctrl #(.N_ROWS(N_ROWS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cfg_start),
        .wr_i      (cfg_wr),
        .erase_o   (erase),
        .we_o      (we),
        .addr_o    (addr),
        .loading_o (loading)
    );

    sop_conn_store #(.N_ROWS(N_ROWS), .LINES(LINES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase_i (erase),
        .we_i    (we),
        .addr_i  (addr),
        .data_i  (cfg_row),
        .rows_o  (rows)
    );

    assign sig = {fb_in, ded_in};

    for (genvar s = 0; s < N_SIG; s++) begin : g_line
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_term
        sop_pterm #(.LINES(LINES)) u_term (
            .clk    (clk),
            .rst_n  (rst_n),
            .conn_i (rows[r]),
            .line_i (lines),
            .term_o (term[r])
        );
    end

    for (genvar n = 0; n < N_OUT; n++) begin : g_or
        localparam int BASE = sop_pkg::out_base(n, N_OUT, MIN_TERMS, TERM_STEP);
        localparam int SIZE = sop_pkg::sum_size(n, N_OUT, MIN_TERMS, TERM_STEP);
        assign oe_raw[n]  = term[BASE];
        assign sum_raw[n] = |term[BASE+1 +: SIZE];
    end

    assign sum_o    = loading ? '0   : sum_raw;
    assign oe_o     = loading ? '0   : oe_raw;
    assign preset_o = loading ? 1'b0 : term[ROW_PRESET];
    assign clear_o  = loading ? 1'b0 : term[ROW_CLEAR];

endmodule

// File: tb/sim_sop_array.sv
module sim_sop_array;

    localparam int NR = 132;
    localparam int SZ [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    localparam logic [21:0] VEC [16] = '{
        22'h000000, 22'h3FFFFF, 22'h155555, 22'h2AAAAA,
        22'h000FFF, 22'h3FF000, 22'h0F0F0F, 22'h30F0F0,
        22'h000001, 22'h200000, 22'h123456, 22'h3ABCDE,
        22'h0C3C3C, 22'h33CC33, 22'h1E1E1E, 22'h0007FF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [43:0] cfg_row = '0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_o, oe_o;
    logic        preset_o, clear_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [43:0] map [NR];

    always #2 clk = ~clk;

    sop_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_wr(cfg_wr),
        .cfg_row(cfg_row), .ded_in(ded_in), .fb_in(fb_in),
        .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o), .clear_o(clear_o)
    );

    function automatic logic model_term(input logic [43:0] row, input logic [21:0] sg);
        for (int s = 0; s < 22; s++) begin
            if (row[2*s] && !sg[s]) return 1'b0;
            if (row[2*s+1] && sg[s]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [21:0] model_out(input logic [21:0] sg);
        logic [9:0] es, eo;
        int base;
        base = 0;
        for (int n = 0; n < 10; n++) begin
            eo[n] = model_term(map[base], sg);
            es[n] = 1'b0;
            for (int t = 0; t < SZ[n]; t++) es[n] |= model_term(map[base+1+t], sg);
            base += 1 + SZ[n];
        end
        return {es, eo, model_term(map[130], sg), model_term(map[131], sg)};
    endfunction

    task automatic check(input string req, input logic [21:0] exp);
        logic [21:0] act;
        act = {sum_o, oe_o, preset_o, clear_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [21:0] v);
        @(negedge clk);
        {fb_in, ded_in} = v;
        #1;
    endtask

    task automatic load(input int nrows, input bit busy_check);
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        if (busy_check) begin
            #1;
            check("R8 outputs held low while loading", 22'h0);
        end
        for (int r = 0; r < nrows; r++) begin
            cfg_wr = 1'b1;
            cfg_row = map[r];
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        cfg_row = '0;
    endtask

    task automatic random_map();
        for (int r = 0; r < NR; r++) begin
            map[r] = '0;
            repeat ($urandom % 4) map[r][$urandom % 44] = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b3, b9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: erased after reset, every term true
        apply(22'h155555);
        check("R6 reset leaves erased array", 22'h3FFFFF);

        // Directed map: R1 R2 R3 R4 R5
        for (int r = 0; r < NR; r++) map[r] = 44'h3;
        b3 = 0;
        for (int n = 0; n < 3; n++) b3 += 1 + SZ[n];
        b9 = 0;
        for (int n = 0; n < 9; n++) b9 += 1 + SZ[n];
        map[b3 + SZ[3]] = 44'h0 | (44'h1 << 29);   // last sum term of output 3: fb_in[2] inverted
        map[b9] = 44'h1 << 42;                       // enable of output 9: fb_in[9] true
        map[130] = 44'h1 << 10;                      // preset: ded_in[5] true
        map[131] = 44'h0;                            // clear erased
        load(NR, 1'b1);
        #1;
        // R9: new map live in the cycle after the last write
        check("R9 map active after last row", model_out({fb_in, ded_in}));
        apply(22'h000000);
        check("R1 R4 inverted feedback line drives output 3", {10'h008, 10'h000, 1'b0, 1'b1});
        apply({10'h004, 12'h020});
        check("R1 R5 preset follows ded_in[5], output 3 off", {10'h000, 10'h000, 1'b1, 1'b1});
        apply({10'h200, 12'h000});
        check("R2 R3 enable 9 true, conflicts false, erased clear true", {10'h008, 10'h200, 1'b0, 1'b1});

        // R5: random maps against the model
        for (int m = 0; m < 3; m++) begin
            random_map();
            load(NR, 1'b0);
            for (int i = 0; i < 16; i++) begin
                apply(VEC[i]);
                check("R5 random map sum/enable/preset/clear", model_out(VEC[i]));
            end
        end

        // R11: stray write in run
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_row = '1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_row = '0;
        for (int i = 0; i < 4; i++) begin
            apply(VEC[i]);
            check("R11 write ignored in run", model_out(VEC[i]));
        end

        // R10: restart mid-load
        for (int r = 0; r < NR; r++) map[r] = '1;
        load(50, 1'b0);
        random_map();
        load(NR, 1'b1);
        for (int i = 4; i < 12; i++) begin
            apply(VEC[i]);
            check("R10 restart reloads from row 0", model_out(VEC[i]));
        end

        // R7: start erases before any write; partial load leaves rest erased
        for (int r = 0; r < NR; r++) map[r] = '0;
        map[0] = 44'h3;
        load(1, 1'b0);
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int r = 0; r < NR; r++) begin
            cfg_wr = 1'b1;
            cfg_row = map[r];
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        apply(22'h2AAAAA);
        check("R7 erase plus full load gives map", {10'h3FF, 10'h3FE, 1'b1, 1'b1});

        // R6: reset mid-run returns to erased state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(22'h000000);
        check("R6 reset erases loaded map", 22'h3FFFFF);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule